// File: doc/BRIEF.md
# Match Result Next-Table Resolver

This block sits after a match table's RAM lookup and the gateway comparison that goes with it. It combines the two outcomes into one result: a final hit flag, a final payload and an 8-bit pointer to the table that runs next. That result feeds the predication logic further down the pipeline. The gateway wins whenever it inhibits. In that case the result takes the hit path, carries the gateway payload, and uses the gateway's own next-table pointer. A table configured as having no match data can only reach the hit path through such an inhibit.

Without an inhibit, a hit takes its next-table pointer from the matched entry. A static mode input picks one of two ways to do this:
- The entry's full 8-bit pointer passes straight through.
- A 3-bit selector stored with the entry indexes a small indirection map of eight pointers. This lets an entry spend 3 bits on the choice instead of 8.

A miss uses a configured miss pointer. The indirection map and the miss pointer are loaded through a synchronous configuration write port.

Each lookup is presented with a valid strobe. The result appears one clock later with its own valid strobe.

Top module: `nt_resolver`

## Requirements
- R1: After reset, outValid, outHit, outPayload and outNextPtr are all zero. All eight map entries and the miss pointer read as zero.
- R2: outValid equals inValid from the previous clock cycle. A result therefore appears exactly one cycle after its inputs.
- R3: On a valid lookup with gwInhibit high, the result has outHit=1, outPayload=gwPayload and outNextPtr=gwNextPtr. This holds whatever matchHit, noMatchData and the mode input are. An all-zero gateway payload stays zero on the output.
- R4: On a valid lookup without inhibit and with noMatchData=1, the result is a miss even when matchHit=1.
- R5: A miss (no inhibit, and no effective hit) gives outHit=0, outPayload=0 and outNextPtr equal to the configured miss pointer.
- R6: A non-inhibited hit with useMap=0 gives outHit=1, outPayload=entryPayload and outNextPtr=entryPtr.
- R7: A non-inhibited hit with useMap=1 gives outNextPtr equal to map entry entrySel (0..7) and outPayload=entryPayload.
- R8: A configuration write (cfgWrEn=1) behaves as follows, and takes effect for lookups from the next cycle on:
  - cfgAddr 0..7 writes that map entry.
  - cfgAddr 8 writes the miss pointer.
  - cfgAddr 9..15 changes nothing.
- R9: While inValid is low, outHit, outPayload and outNextPtr hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | 0..7 map entry, 8 miss pointer |
| cfgData | input | 8 | Pointer value to write |
| useMap | input | 1 | 1: next table from the map via entrySel; 0: from entryPtr |
| noMatchData | input | 1 | Table has no match data, so RAM result is always a miss |
| inValid | input | 1 | Lookup inputs are valid this cycle |
| matchHit | input | 1 | RAM match hit flag |
| entrySel | input | 3 | Map selector stored with the matched entry |
| entryPtr | input | 8 | Direct next-table pointer stored with the entry |
| entryPayload | input | 8 | Payload of the matched entry |
| gwInhibit | input | 1 | Gateway row matched with inhibit |
| gwPayload | input | 8 | Gateway payload |
| gwNextPtr | input | 8 | Gateway next-table pointer |
| outValid | output | 1 | Result valid |
| outHit | output | 1 | Final hit/miss path |
| outPayload | output | 8 | Final payload |
| outNextPtr | output | 8 | Final next-table pointer |

## Verification
The hardest case to reach from the ports is a RAM hit that must still be overridden. A table with no match data drives matchHit high, yet it must still take the miss path. The same table must take the hit path only when the gateway inhibits. The bench covers this by applying matchHit=1 with noMatchData=1 both with and without an inhibit, and checks that both outcomes differ from the ordinary hit result. Ignored configuration addresses are checked in a similar way. After a write to an unused address, the bench reads back the miss pointer and a map entry through ordinary lookups.

// File: rtl/nt_resolver_pkg.sv
package nt_resolver_pkg;
  typedef enum logic [1:0] {
    PATH_GATEWAY = 2'd0,
    PATH_DIRECT  = 2'd1,
    PATH_MAPPED  = 2'd2,
    PATH_MISS    = 2'd3
  } pathSel_e;

  typedef struct packed {
    logic     load;
    logic     hit;
    pathSel_e path;
  } ctrlStrobes_t;
endpackage

// File: rtl/nt_resolver_ctrl.sv
module nt_resolver_ctrl
  import nt_resolver_pkg::*;
(
  input  logic         inValid,
  input  logic         matchHit,
  input  logic         noMatchData,
  input  logic         useMap,
  input  logic         gwInhibit,
  output ctrlStrobes_t strobes
);
  logic effHit;

  // A table with no match data never produces a RAM hit.
  assign effHit = matchHit & ~noMatchData;

  always_comb begin
    strobes.load = inValid;
    if (gwInhibit) begin
      strobes.hit  = 1'b1;
      strobes.path = PATH_GATEWAY;
    end else if (effHit) begin
      strobes.hit  = 1'b1;
      strobes.path = useMap ? PATH_MAPPED : PATH_DIRECT;
    end else begin
      strobes.hit  = 1'b0;
      strobes.path = PATH_MISS;
    end
  end
endmodule

// File: rtl/nt_resolver_dp.sv
module nt_resolver_dp
  import nt_resolver_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int PAY_W     = 8,
  parameter int MAP_DEPTH = 8,
  localparam int SEL_W    = $clog2(MAP_DEPTH),
  localparam int ADDR_W   = SEL_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [PTR_W-1:0]   cfgData,
  input  ctrlStrobes_t       strobes,
  input  logic [SEL_W-1:0]   entrySel,
  input  logic [PTR_W-1:0]   entryPtr,
  input  logic [PAY_W-1:0]   entryPayload,
  input  logic [PAY_W-1:0]   gwPayload,
  input  logic [PTR_W-1:0]   gwNextPtr,
  output logic               outValid,
  output logic               outHit,
  output logic [PAY_W-1:0]   outPayload,
  output logic [PTR_W-1:0]   outNextPtr
);
  localparam logic [ADDR_W-1:0] MISS_ADDR = ADDR_W'(MAP_DEPTH);

  logic [PTR_W-1:0] mapMem [MAP_DEPTH];
  logic [PTR_W-1:0] missPtr;
  logic [PTR_W-1:0] nextPtrD;
  logic [PAY_W-1:0] payloadD;

  for (genvar i = 0; i < MAP_DEPTH; i++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mapMem[i] <= '0;
      end else if (cfgWrEn && cfgAddr == ADDR_W'(i)) begin
        mapMem[i] <= cfgData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missPtr <= '0;
    end else if (cfgWrEn && cfgAddr == MISS_ADDR) begin
      missPtr <= cfgData;
    end
  end

  always_comb begin
    unique case (strobes.path)
      PATH_GATEWAY: begin
        nextPtrD = gwNextPtr;
        payloadD = gwPayload;
      end
      PATH_DIRECT: begin
        nextPtrD = entryPtr;
        payloadD = entryPayload;
      end
      PATH_MAPPED: begin
        nextPtrD = mapMem[entrySel];
        payloadD = entryPayload;
      end
      default: begin
        nextPtrD = missPtr;
        payloadD = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outHit     <= 1'b0;
      outPayload <= '0;
      outNextPtr <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        outHit     <= strobes.hit;
        outPayload <= payloadD;
        outNextPtr <= nextPtrD;
      end
    end
  end
endmodule

// File: rtl/nt_resolver.sv
module nt_resolver
  import nt_resolver_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int PAY_W     = 8,
  parameter int MAP_DEPTH = 8,
  localparam int SEL_W    = $clog2(MAP_DEPTH),
  localparam int ADDR_W   = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [PTR_W-1:0]  cfgData,
  input  logic              useMap,
  input  logic              noMatchData,
  input  logic              inValid,
  input  logic              matchHit,
  input  logic [SEL_W-1:0]  entrySel,
  input  logic [PTR_W-1:0]  entryPtr,
  input  logic [PAY_W-1:0]  entryPayload,
  input  logic              gwInhibit,
  input  logic [PAY_W-1:0]  gwPayload,
  input  logic [PTR_W-1:0]  gwNextPtr,
  output logic              outValid,
  output logic              outHit,
  output logic [PAY_W-1:0]  outPayload,
  output logic [PTR_W-1:0]  outNextPtr
);
  ctrlStrobes_t strobes;

  nt_resolver_ctrl u_ctrl (
    .inValid     (inValid),
    .matchHit    (matchHit),
    .noMatchData (noMatchData),
    .useMap      (useMap),
    .gwInhibit   (gwInhibit),
    .strobes     (strobes)
  );

  nt_resolver_dp #(
    .PTR_W     (PTR_W),
    .PAY_W     (PAY_W),
    .MAP_DEPTH (MAP_DEPTH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgAddr      (cfgAddr),
    .cfgData      (cfgData),
    .strobes      (strobes),
    .entrySel     (entrySel),
    .entryPtr     (entryPtr),
    .entryPayload (entryPayload),
    .gwPayload    (gwPayload),
    .gwNextPtr    (gwNextPtr),
    .outValid     (outValid),
    .outHit       (outHit),
    .outPayload   (outPayload),
    .outNextPtr   (outNextPtr)
  );
endmodule

// File: rtl/nt_resolver_chk.sv
module nt_resolver_chk #(
  parameter int PTR_W     = 8,
  parameter int PAY_W     = 8,
  parameter int MAP_DEPTH = 8,
  localparam int SEL_W    = $clog2(MAP_DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             useMap,
  input logic             noMatchData,
  input logic             inValid,
  input logic             matchHit,
  input logic [PTR_W-1:0] entryPtr,
  input logic [PAY_W-1:0] entryPayload,
  input logic             gwInhibit,
  input logic [PAY_W-1:0] gwPayload,
  input logic [PTR_W-1:0] gwNextPtr,
  input logic             outValid,
  input logic             outHit,
  input logic [PAY_W-1:0] outPayload,
  input logic [PTR_W-1:0] outNextPtr
);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R3
  gw_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && gwInhibit) |=>
      (outHit && outNextPtr == $past(gwNextPtr) && outPayload == $past(gwPayload)));

  // R4
  no_match_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !gwInhibit && noMatchData) |=> !outHit);

  // R5
  miss_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !gwInhibit && !(matchHit && !noMatchData)) |=> (!outHit && outPayload == '0));

  // R6
  direct_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !gwInhibit && matchHit && !noMatchData && !useMap) |=>
      (outHit && outNextPtr == $past(entryPtr) && outPayload == $past(entryPayload)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outHit) && $stable(outPayload) && $stable(outNextPtr)));
endmodule

bind nt_resolver nt_resolver_chk #(
  .PTR_W     (PTR_W),
  .PAY_W     (PAY_W),
  .MAP_DEPTH (MAP_DEPTH)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .useMap       (useMap),
  .noMatchData  (noMatchData),
  .inValid      (inValid),
  .matchHit     (matchHit),
  .entryPtr     (entryPtr),
  .entryPayload (entryPayload),
  .gwInhibit    (gwInhibit),
  .gwPayload    (gwPayload),
  .gwNextPtr    (gwNextPtr),
  .outValid     (outValid),
  .outHit       (outHit),
  .outPayload   (outPayload),
  .outNextPtr   (outNextPtr)
);

// File: tb/nt_resolver_tb.sv
module nt_resolver_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       useMap = 1'b0;
  logic       noMatchData = 1'b0;
  logic       inValid = 1'b0;
  logic       matchHit = 1'b0;
  logic [2:0] entrySel = '0;
  logic [7:0] entryPtr = '0;
  logic [7:0] entryPayload = '0;
  logic       gwInhibit = 1'b0;
  logic [7:0] gwPayload = '0;
  logic [7:0] gwNextPtr = '0;
  logic       outValid;
  logic       outHit;
  logic [7:0] outPayload;
  logic [7:0] outNextPtr;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdlMap [8];
  logic [7:0] mdlMiss;

  always #10 clk = ~clk;

  nt_resolver u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .useMap(useMap), .noMatchData(noMatchData), .inValid(inValid), .matchHit(matchHit),
    .entrySel(entrySel), .entryPtr(entryPtr), .entryPayload(entryPayload),
    .gwInhibit(gwInhibit), .gwPayload(gwPayload), .gwNextPtr(gwNextPtr),
    .outValid(outValid), .outHit(outHit), .outPayload(outPayload), .outNextPtr(outNextPtr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a < 4'd8) mdlMap[a[2:0]] = d;
    else if (a == 4'd8) mdlMiss = d;
  endtask

  // Drive one lookup, return result sampled one cycle later.
  task automatic lookup(input logic hit, input logic inh, input logic [2:0] sel,
                        input logic [7:0] ptr, input logic [7:0] pay,
                        input logic [7:0] gp, input logic [7:0] gn);
    @(negedge clk);
    inValid = 1'b1; matchHit = hit; gwInhibit = inh; entrySel = sel;
    entryPtr = ptr; entryPayload = pay; gwPayload = gp; gwNextPtr = gn;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectOut(input string req, input logic h, input logic [7:0] p, input logic [7:0] n);
    check({req, " valid"}, outValid, 1);
    check({req, " hit"}, outHit, h);
    check({req, " payload"}, outPayload, p);
    check({req, " next"}, outNextPtr, n);
  endtask

  task automatic testReset();
    check("R1 valid", outValid, 0);
    check("R1 hit", outHit, 0);
    check("R1 payload", outPayload, 0);
    check("R1 next", outNextPtr, 0);
    noMatchData = 1'b0; useMap = 1'b1;
    lookup(1'b1, 1'b0, 3'd5, 8'h11, 8'h22, 8'h0, 8'h0);
    expectOut("R1 map zero", 1'b1, 8'h22, 8'h00);
    lookup(1'b0, 1'b0, 3'd0, 8'h11, 8'h22, 8'h0, 8'h0);
    expectOut("R1 miss zero", 1'b0, 8'h00, 8'h00);
  endtask

  task automatic testConfig();
    for (int i = 0; i < 8; i++) cfgWrite(4'(i), 8'(8'h40 + i * 8'h13));
    cfgWrite(4'd8, 8'hA5);
    useMap = 1'b1; noMatchData = 1'b0;
    for (int i = 0; i < 8; i++) begin
      lookup(1'b1, 1'b0, 3'(i), 8'hFF, 8'(i), 8'h0, 8'h0);
      expectOut("R7 mapped", 1'b1, 8'(i), mdlMap[i]);
    end
    lookup(1'b0, 1'b0, 3'd0, 8'hFF, 8'h99, 8'h0, 8'h0);
    expectOut("R5 miss", 1'b0, 8'h00, mdlMiss);
  endtask

  task automatic testIgnoredAddr();
    for (int a = 9; a < 16; a++) cfgWrite(4'(a), 8'hEE);
    useMap = 1'b1;
    lookup(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h0, 8'h0);
    expectOut("R8 miss unchanged", 1'b0, 8'h00, 8'hA5);
    lookup(1'b1, 1'b0, 3'd4, 8'h00, 8'h01, 8'h0, 8'h0);
    expectOut("R8 map unchanged", 1'b1, 8'h01, mdlMap[4]);
    cfgWrite(4'd4, 8'h3C);
    lookup(1'b1, 1'b0, 3'd4, 8'h00, 8'h02, 8'h0, 8'h0);
    expectOut("R8 rewrite", 1'b1, 8'h02, 8'h3C);
  endtask

  task automatic testDirect();
    useMap = 1'b0; noMatchData = 1'b0;
    lookup(1'b1, 1'b0, 3'd2, 8'h7E, 8'hC3, 8'h0, 8'h0);
    expectOut("R6 direct", 1'b1, 8'hC3, 8'h7E);
    lookup(1'b1, 1'b0, 3'd7, 8'h01, 8'h5A, 8'h0, 8'h0);
    expectOut("R6 direct2", 1'b1, 8'h5A, 8'h01);
  endtask

  task automatic testGateway();
    useMap = 1'b1; noMatchData = 1'b0;
    lookup(1'b0, 1'b1, 3'd1, 8'h10, 8'h20, 8'h33, 8'h44);
    expectOut("R3 gw on miss", 1'b1, 8'h33, 8'h44);
    lookup(1'b1, 1'b1, 3'd1, 8'h10, 8'h20, 8'h00, 8'h9B);
    expectOut("R3 gw zero payload", 1'b1, 8'h00, 8'h9B);
    noMatchData = 1'b1;
    lookup(1'b1, 1'b1, 3'd1, 8'h10, 8'h20, 8'h06, 8'h61);
    expectOut("R3 gw no-match table", 1'b1, 8'h06, 8'h61);
  endtask

  task automatic testNoMatch();
    noMatchData = 1'b1; useMap = 1'b0;
    lookup(1'b1, 1'b0, 3'd3, 8'h77, 8'h88, 8'h0, 8'h0);
    expectOut("R4 forced miss", 1'b0, 8'h00, 8'hA5);
    noMatchData = 1'b0;
  endtask

  task automatic testLatencyHold();
    useMap = 1'b0; noMatchData = 1'b0;
    lookup(1'b1, 1'b0, 3'd0, 8'h5D, 8'h6E, 8'h0, 8'h0);
    check("R2 valid after one cycle", outValid, 1);
    // change inputs while inValid low
    matchHit = 1'b0; gwInhibit = 1'b1; gwNextPtr = 8'hFF; gwPayload = 8'hFF;
    @(negedge clk);
    check("R2 valid drops", outValid, 0);
    check("R9 hold hit", outHit, 1);
    check("R9 hold payload", outPayload, 8'h6E);
    check("R9 hold next", outNextPtr, 8'h5D);
    gwInhibit = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdlMap[i] = '0;
    mdlMiss = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testIgnoredAddr();
    testDirect();
    testGateway();
    testNoMatch();
    testLatencyHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule